// File: doc/BRIEF.md
# LCD Panel Control Signal Conditioner

This block sits between a display timing generator and the pins of an LCD panel. Each cycle of the functional clock it receives four internal active-high strobes: frame marker, line pulse, output enable and data valid. It also receives a vertical-sync idle flag and a set of static configuration inputs. From these it produces a pixel-rate enable pulse and a shift clock for the panel. It drives the frame marker, line pulse and output enable pins with a selectable polarity. For passive panels it also generates the alternating drive-direction signal, which keeps the liquid crystal free of a DC bias.

The pixel divider and the direction toggler each take their ratio from a shadow register. A shadow register is reloaded only at the rising edge of the frame marker, so a ratio written in the middle of a frame takes effect cleanly at the start of the next frame. In active-matrix (TFT) mode the direction signal is held low. The shift clock can then be stopped while no pixel data flows, or while vertical sync is idle. The sense of the shift clock's active edge depends on the polarity bit and also on the panel mode.

Top module: `lcd_sig_cond`

## Requirements
- R1: `pix_en` is high on one cycle out of every (S+1) cycles, where S is the divider shadow value. When S is 0, `pix_en` is high on every cycle. If the shadow value drops below the running count, the next cycle is a pulse.
- R2: On a cycle where `frm_i` is high and was low on the previous cycle (a frame start), both shadow registers load `cfg_pcd` and `cfg_acd`. The new values take effect from the following cycle, and the cycle of the frame start still uses the old values. After reset, both shadows are 0.
- R3: In passive mode (`cfg_tft`=0), `acd_o` inverts on every (A+1)-th tick of the selected source, where A is the direction shadow value. After reset, both the tick count and `acd_o` are 0.
- R4: With `cfg_acd_src`=0, a tick is a frame start. With `cfg_acd_src`=1, a tick is a cycle where `lp_i` is high and was low before. A pulse that is several cycles long counts once.
- R5: With `cfg_tft`=1, `acd_o` is 0 one cycle later and the tick count is cleared.
- R6: `frm_o` and `lp_o` carry the previous cycle's `frm_i` and `lp_i`, XORed with the current `cfg_frm_pol` and `cfg_lp_pol` (0 means active high).
- R7: `oe_o` carries the previous cycle's `oe_i`, forced inactive when that cycle had `cfg_tft`=1, `dv_i`=0 and `cfg_keep_clk`=0. The result is XORed with the current `cfg_oe_pol`.
- R8: The internal shift-clock phase flips on each cycle where `pix_en` is high and the clock is allowed to run. `sclk_o` is this phase XORed with an inversion bit. The inversion bit is `cfg_sclk_pol` in TFT mode and its complement in passive mode. So, with the phase rising as the active moment, pol=0 gives a falling active edge in passive mode and a rising one in TFT mode.
- R9: In TFT mode the shift-clock phase returns to 0 on the next cycle in either of two cases. The first is `dv_i`=0 while `cfg_keep_clk`=0. The second is `vs_idle_i`=1 while `cfg_sclk_idle_en`=0. In passive mode the phase is never held.
- R10: While `rst_n` is low (synchronous), all state clears: the divider count, both shadows, the phase, the tick count, `acd_o`, and the registered strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frm_i | input | 1 | Frame marker, active high |
| lp_i | input | 1 | Line pulse, active high |
| oe_i | input | 1 | Output enable, active high |
| dv_i | input | 1 | Pixel data is being output |
| vs_idle_i | input | 1 | Vertical sync is idle |
| cfg_pcd | input | 6 | Pixel divider value (ratio = value+1) |
| cfg_acd | input | 7 | Direction toggle period (ticks = value+1) |
| cfg_acd_src | input | 1 | Direction tick source: 0 frame, 1 line |
| cfg_tft | input | 1 | 1 = active-matrix mode |
| cfg_frm_pol | input | 1 | Frame marker pin polarity, 1 = active low |
| cfg_lp_pol | input | 1 | Line pulse pin polarity, 1 = active low |
| cfg_oe_pol | input | 1 | Output enable pin polarity, 1 = active low |
| cfg_sclk_pol | input | 1 | Shift clock edge polarity |
| cfg_keep_clk | input | 1 | TFT: shift clock runs without pixel data |
| cfg_sclk_idle_en | input | 1 | TFT: shift clock runs during vsync idle |
| pix_en | output | 1 | Pixel-rate enable pulse |
| sclk_o | output | 1 | Shift clock pin |
| frm_o | output | 1 | Frame marker pin |
| lp_o | output | 1 | Line pulse pin |
| oe_o | output | 1 | Output enable pin |
| acd_o | output | 1 | Alternating drive-direction pin |

## Verification
A frame start can fall in the same cycle as a direction-toggler tick, and also as the divider's terminal count. That cycle must still use the old shadow values, and the new values apply only afterwards. The bench produces this collision by running frames with periods that are not multiples of the divide ratio, and by choosing frame-sourced ticks, which coincide with every shadow load. Each such cycle is judged against a behavioural model that reads the old shadow before it stores the new one.

// File: rtl/lcd_sig_pkg.sv
package lcd_sig_pkg;

  // Inversion applied to the shift-clock phase; the sense flips with panel mode.
  function automatic logic sclk_invert(input logic tft, input logic pol);
    return tft ? pol : ~pol;
  endfunction

  // Whether the shift clock may run this cycle.
  function automatic logic sclk_allowed(input logic tft, input logic dv,
                                        input logic keep, input logic vs_idle,
                                        input logic idle_en);
    return !tft || ((dv || keep) && (!vs_idle || idle_en));
  endfunction

  // Whether the output enable strobe may pass this cycle.
  function automatic logic oe_allowed(input logic tft, input logic dv, input logic keep);
    return !tft || dv || keep;
  endfunction

endpackage

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] ratio_in,
  output logic             tick,
  output logic [DIV_W-1:0] ratio_sh
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= ratio_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      ratio_sh <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (load) ratio_sh <= ratio_in;
    end
  end
endmodule

// File: rtl/lcd_acd_gen.sv
module lcd_acd_gen #(
  parameter int ACD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACD_W-1:0] period_in,
  input  logic             hold,
  input  logic             tick,
  output logic             acd,
  output logic [ACD_W-1:0] period_sh
);
  logic [ACD_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= period_sh);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      acd       <= 1'b0;
      period_sh <= '0;
    end else begin
      if (load) period_sh <= period_in;
      if (hold) begin
        cnt <= '0;
        acd <= 1'b0;
      end else if (tick) begin
        if (wrap) begin
          cnt <= '0;
          acd <= ~acd;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_sclk_phase.sv
module lcd_sclk_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic run,
  output logic ph
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ph <= 1'b0;
    else if (!run) ph <= 1'b0;
    else if (adv)  ph <= ~ph;
  end
endmodule

// File: rtl/lcd_sig_cond.sv
module lcd_sig_cond #(
  parameter int DIV_W = 6,
  parameter int ACD_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_i,
  input  logic             lp_i,
  input  logic             oe_i,
  input  logic             dv_i,
  input  logic             vs_idle_i,
  input  logic [DIV_W-1:0] cfg_pcd,
  input  logic [ACD_W-1:0] cfg_acd,
  input  logic             cfg_acd_src,
  input  logic             cfg_tft,
  input  logic             cfg_frm_pol,
  input  logic             cfg_lp_pol,
  input  logic             cfg_oe_pol,
  input  logic             cfg_sclk_pol,
  input  logic             cfg_keep_clk,
  input  logic             cfg_sclk_idle_en,
  output logic             pix_en,
  output logic             sclk_o,
  output logic             frm_o,
  output logic             lp_o,
  output logic             oe_o,
  output logic             acd_o
);
  import lcd_sig_pkg::*;

  logic             frm_q, lp_q, oe_q;
  logic             frm_rise, lp_rise, acd_tick;
  logic             sclk_run, sclk_ph;
  logic [DIV_W-1:0] pcd_sh;
  logic [ACD_W-1:0] acd_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_q <= 1'b0;
      lp_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      frm_q <= frm_i;
      lp_q  <= lp_i;
      oe_q  <= oe_i && oe_allowed(cfg_tft, dv_i, cfg_keep_clk);
    end
  end

  assign frm_rise = frm_i && !frm_q;
  assign lp_rise  = lp_i && !lp_q;
  assign acd_tick = !cfg_tft && (cfg_acd_src ? lp_rise : frm_rise);
  assign sclk_run = sclk_allowed(cfg_tft, dv_i, cfg_keep_clk, vs_idle_i, cfg_sclk_idle_en);

  lcd_pix_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(frm_rise), .ratio_in(cfg_pcd),
    .tick(pix_en), .ratio_sh(pcd_sh)
  );

  lcd_acd_gen #(.ACD_W(ACD_W)) u_acd (
    .clk(clk), .rst_n(rst_n), .load(frm_rise), .period_in(cfg_acd),
    .hold(cfg_tft), .tick(acd_tick), .acd(acd_o), .period_sh(acd_sh)
  );

  lcd_sclk_phase u_ph (
    .clk(clk), .rst_n(rst_n), .adv(pix_en), .run(sclk_run), .ph(sclk_ph)
  );

  assign sclk_o = sclk_ph ^ sclk_invert(cfg_tft, cfg_sclk_pol);
  assign frm_o  = frm_q ^ cfg_frm_pol;
  assign lp_o   = lp_q ^ cfg_lp_pol;
  assign oe_o   = oe_q ^ cfg_oe_pol;
endmodule

// File: rtl/lcd_sig_cond_chk.sv
module lcd_sig_cond_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_en,
  input logic [DIV_W-1:0] pcd_sh,
  input logic             frm_rise,
  input logic             acd_tick,
  input logic             acd_o,
  input logic             cfg_tft,
  input logic             dv_i,
  input logic             cfg_keep_clk,
  input logic             sclk_ph
);
  // R1: with a ratio above one and no reload, a pulse is followed by a gap
  a_r1_pulse_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && pcd_sh != '0 && !frm_rise) |=> !pix_en);

  // R3: the direction output moves only on a tick
  a_r3_acd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!acd_tick && !cfg_tft) |=> $stable(acd_o));

  // R5: TFT mode holds the direction output low
  a_r5_tft_static: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tft |=> !acd_o);

  // R8: the phase rises only after a pixel enable
  a_r8_phase_on_pix: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_ph) |-> $past(pix_en));

  // R9: no pixel data and no keep-running request parks the phase
  a_r9_gate_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_tft && !dv_i && !cfg_keep_clk) |=> !sclk_ph);
endmodule

bind lcd_sig_cond lcd_sig_cond_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .pcd_sh(pcd_sh),
  .frm_rise(frm_rise), .acd_tick(acd_tick), .acd_o(acd_o), .cfg_tft(cfg_tft),
  .dv_i(dv_i), .cfg_keep_clk(cfg_keep_clk), .sclk_ph(sclk_ph)
);

// File: tb/lcd_sig_cond_test.sv
module lcd_sig_cond_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic frm_i = 0, lp_i = 0, oe_i = 0, dv_i = 0, vs_idle_i = 0;
  logic [5:0] cfg_pcd = '0;
  logic [6:0] cfg_acd = '0;
  logic cfg_acd_src = 0, cfg_tft = 0, cfg_frm_pol = 0, cfg_lp_pol = 0, cfg_oe_pol = 0;
  logic cfg_sclk_pol = 0, cfg_keep_clk = 0, cfg_sclk_idle_en = 0;
  logic pix_en, sclk_o, frm_o, lp_o, oe_o, acd_o;

  lcd_sig_cond uut (
    .clk(clk), .rst_n(rst_n), .frm_i(frm_i), .lp_i(lp_i), .oe_i(oe_i), .dv_i(dv_i),
    .vs_idle_i(vs_idle_i), .cfg_pcd(cfg_pcd), .cfg_acd(cfg_acd), .cfg_acd_src(cfg_acd_src),
    .cfg_tft(cfg_tft), .cfg_frm_pol(cfg_frm_pol), .cfg_lp_pol(cfg_lp_pol),
    .cfg_oe_pol(cfg_oe_pol), .cfg_sclk_pol(cfg_sclk_pol), .cfg_keep_clk(cfg_keep_clk),
    .cfg_sclk_idle_en(cfg_sclk_idle_en), .pix_en(pix_en), .sclk_o(sclk_o),
    .frm_o(frm_o), .lp_o(lp_o), .oe_o(oe_o), .acd_o(acd_o)
  );

  int vecs = 0, bad = 0;
  bit done = 0;
  string phase = "R10 reset";

  // behavioural reference state
  int m_cnt, m_pcd, m_ph, m_tk, m_asd, m_acd, m_frm, m_lp, m_oe;

  task automatic cmp(input string req, input logic act, input logic exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s [%s] t=%0t actual=%0b expected=%0b", req, phase, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    logic inv;
    inv = cfg_tft ? cfg_sclk_pol : !cfg_sclk_pol;
    cmp("R1 pix_en", pix_en, m_cnt >= m_pcd);
    cmp("R8 sclk_o", sclk_o, (m_ph != 0) ^ inv);
    cmp("R6 frm_o", frm_o, (m_frm != 0) ^ cfg_frm_pol);
    cmp("R6 lp_o", lp_o, (m_lp != 0) ^ cfg_lp_pol);
    cmp("R7 oe_o", oe_o, (m_oe != 0) ^ cfg_oe_pol);
    cmp("R3 acd_o", acd_o, m_acd != 0);
  endtask

  task automatic model_edge();
    bit rise, lrise, pe, run, tick;
    if (!rst_n) begin
      m_cnt = 0; m_pcd = 0; m_ph = 0; m_tk = 0; m_asd = 0; m_acd = 0;
      m_frm = 0; m_lp = 0; m_oe = 0;
      return;
    end
    rise  = frm_i && (m_frm == 0);
    lrise = lp_i && (m_lp == 0);
    pe    = (m_cnt >= m_pcd);
    run   = !cfg_tft || ((dv_i || cfg_keep_clk) && (!vs_idle_i || cfg_sclk_idle_en));
    tick  = !cfg_tft && (cfg_acd_src ? lrise : rise);
    if (!run) m_ph = 0; else if (pe) m_ph = 1 - m_ph;
    if (cfg_tft) begin
      m_tk = 0; m_acd = 0;
    end else if (tick) begin
      if (m_tk >= m_asd) begin m_tk = 0; m_acd = 1 - m_acd; end
      else m_tk = m_tk + 1;
    end
    m_cnt = pe ? 0 : m_cnt + 1;
    if (rise) begin m_pcd = int'(cfg_pcd); m_asd = int'(cfg_acd); end
    m_frm = frm_i;
    m_lp  = lp_i;
    m_oe  = (oe_i && (!cfg_tft || dv_i || cfg_keep_clk)) ? 1 : 0;
  endtask

  task automatic cycle();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n, input int fper, input int lper);
    for (int i = 0; i < n; i++) begin
      frm_i     = (i % fper) < 2;
      lp_i      = (i % lper) < 3;
      oe_i      = ($urandom % 4) != 0;
      dv_i      = ($urandom % 3) != 0;
      vs_idle_i = ($urandom % 5) == 0;
      cycle();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cycle();
    cycle();
    // R10: reset state at the ports
    cmp("R10 pix_en reset", pix_en, 1'b1);
    cmp("R10 acd_o reset", acd_o, 1'b0);
    cmp("R10 sclk_o reset", sclk_o, 1'b1);
    rst_n = 1'b1;

    phase = "R1 bypass"; cfg_pcd = 6'd0; run(60, 40, 7);
    phase = "R2 R1 ratio reload"; cfg_pcd = 6'd3; cfg_acd = 7'd2; run(200, 37, 7);
    phase = "R2 R1 max ratio"; cfg_pcd = 6'd63; run(300, 41, 9);
    phase = "R3 R4 frame ticks"; cfg_pcd = 6'd5; cfg_acd = 7'd1; cfg_acd_src = 0; run(300, 23, 7);
    phase = "R3 R4 line ticks"; cfg_acd = 7'd3; cfg_acd_src = 1; run(300, 50, 6);
    phase = "R6 R7 inverted pins"; cfg_frm_pol = 1; cfg_lp_pol = 1; cfg_oe_pol = 1; cfg_sclk_pol = 1;
    run(150, 31, 5);
    phase = "R5 R9 tft gated"; cfg_tft = 1; cfg_pcd = 6'd1; cfg_keep_clk = 0; cfg_sclk_idle_en = 0;
    run(200, 29, 7);
    phase = "R9 R7 tft keep clock"; cfg_keep_clk = 1; cfg_sclk_pol = 0; run(200, 29, 7);
    phase = "R9 tft idle enable"; cfg_sclk_idle_en = 1; run(200, 29, 7);
    phase = "R5 R3 back to passive"; cfg_tft = 0; cfg_acd_src = 0; cfg_acd = 7'd0; cfg_pcd = 6'd0;
    run(200, 13, 7);
    phase = "R8 passive pol"; cfg_sclk_pol = 1; cfg_pcd = 6'd2; run(100, 19, 7);
    phase = "R10 mid-run reset"; rst_n = 1'b0; cycle(); rst_n = 1'b1; run(50, 17, 7);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule